// File: doc/BRIEF.md
# Destination Address Receive Filter

This block decides whether an incoming Ethernet frame should be kept, based only on the 48-bit destination address at its start. The receive path delivers the address one byte per cycle, with a start-of-frame marker on the first byte. The block accepts the frame if any of the following holds: promiscuous mode is on, the address is broadcast, the address is a group address that the multicast policy admits, or the address matches the programmed station address.

Multicast filtering uses a 64-bucket table. The bucket of a group address is the top six bits of the Ethernet CRC-32 of its six address bytes. The CRC is accumulated as the bytes arrive, so the decision is ready one clock after the sixth byte. A write-only register port loads the station address, the table and the mode bits. Each decision is a one-cycle pulse carrying an accept flag and a reason code.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset no decision is pending, the station address is all zeros, every table bit is clear and both mode bits are clear.
- R2: A decision pulse (`dec_valid`) lasts exactly one cycle. It appears in the cycle after the clock edge that samples the sixth byte counted from a byte with `rx_sof` set. A byte with `rx_sof` set restarts the count. Bytes that arrive after the sixth byte, or without a preceding start byte, produce nothing.
- R3: Register writes use the following map. Address 0 loads station bits 31:0. Address 1 loads station bits 47:32 from `cfg_wdata[15:0]`, and the upper data bits are ignored. Address 2 loads table bits 31:0. Address 3 loads table bits 63:32. Address 4 loads the mode: bit 1 selects promiscuous and bit 0 selects all-group. Writes to addresses 5 to 7 change nothing. The first address byte on the wire corresponds to station bits 47:40.
- R4: When mode bit 1 is set, every decision accepts with reason 1, including unicast mismatches and broadcasts.
- R5: Outside promiscuous mode, the all-ones address is accepted with reason 2 whatever the table holds.
- R6: With mode bit 0 set and bit 1 clear, any non-broadcast group address is accepted with reason 3 without consulting the table. A group address is one whose first byte has bit 0 set. Unicast frames still need a station match.
- R7: With both mode bits clear, a non-broadcast group address is accepted with reason 4 only if table bit k is set, and is otherwise rejected with reason 0. Here k is CRC bits 31:26. The CRC is preset to all ones, uses polynomial 0x04C11DB7, takes each byte least-significant bit first and is not inverted.
- R8: Outside promiscuous mode, a unicast address is accepted with reason 5 only on an exact match with the station address, and is otherwise rejected with reason 0.
- R9: A register write on the same clock edge that samples the sixth byte does not affect that decision. It does take effect for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| rx_valid | input | 1 | Address byte present this cycle |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_byte | input | 8 | Destination address byte |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_reason | output | 3 | 0 reject, 1 promiscuous, 2 broadcast, 3 all-group, 4 table hit, 5 station match |

## Verification
The hardest case to reach from the ports is a table hit. Each group address maps to a bucket the bench cannot see, and only one of 64 table bits decides the outcome. The bench works out the bucket with its own bit-serial CRC. It programs exactly that bit and shows acceptance. It then clears just that bit while setting all the others, and shows rejection. It also searches for a second group address in a different bucket to show that a neighbouring bit does not leak. A second hard case is a mode write landing on the sixth-byte edge. The bench issues the write together with that byte.

// File: rtl/daf_pkg.sv
`timescale 1ns/1ps
package daf_pkg;

   localparam int DAF_CRC_W = 32;

   typedef enum logic [2:0] {
      RSN_REJECT  = 3'd0,
      RSN_PROMISC = 3'd1,
      RSN_BCAST   = 3'd2,
      RSN_ALLGRP  = 3'd3,
      RSN_HASH    = 3'd4,
      RSN_STATION = 3'd5
   } daf_reason_e;

   typedef struct packed {
      logic promisc;
      logic all_group;
   } daf_mode_t;

   // One byte of CRC, bits taken least-significant first, MSB-side feedback.
   function automatic logic [DAF_CRC_W-1:0] daf_crc_byte(
      input logic [DAF_CRC_W-1:0] crc_in,
      input logic [7:0]           din,
      input logic [DAF_CRC_W-1:0] poly);
      logic [DAF_CRC_W-1:0] c;
      logic                 fb;
      c = crc_in;
      for (int i = 0; i < 8; i++) begin
         fb = c[DAF_CRC_W-1] ^ din[i];
         c  = {c[DAF_CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
      end
      return c;
   endfunction

endpackage

// File: rtl/daf_cfg_regs.sv
`timescale 1ns/1ps
module daf_cfg_regs
   import daf_pkg::*;
#(
   parameter int CFG_DW = 32,
   parameter int CFG_AW = 3,
   parameter int STA_W  = 48,
   parameter int TBL_W  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [CFG_DW-1:0] cfg_wdata,
   output logic [STA_W-1:0]  station,
   output logic [TBL_W-1:0]  table_bits,
   output daf_mode_t         mode
);
   localparam int STA_WORDS = (STA_W + CFG_DW - 1) / CFG_DW;
   localparam int TBL_WORDS = TBL_W / CFG_DW;
   localparam int TBL_BASE  = STA_WORDS;
   localparam int MODE_IDX  = TBL_BASE + TBL_WORDS;
   localparam logic [CFG_AW-1:0] MODE_ADDR = CFG_AW'(MODE_IDX);

   if (TBL_W % CFG_DW != 0) begin : g_chk_tbl
      $error("table width must be a multiple of the register width");
   end
   if (MODE_IDX >= (1 << CFG_AW)) begin : g_chk_map
      $error("register map does not fit the address width");
   end
   if (CFG_DW < 2) begin : g_chk_dw
      $error("register width too small for mode field");
   end

   // Station address words; the last word may be narrower than the bus.
   for (genvar w = 0; w < STA_WORDS; w++) begin : g_sta
      localparam int LO = w * CFG_DW;
      localparam int WW = ((STA_W - LO) < CFG_DW) ? (STA_W - LO) : CFG_DW;
      localparam logic [CFG_AW-1:0] WADDR = CFG_AW'(w);
      logic [WW-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '0;
         else if (cfg_we && cfg_addr == WADDR)
            word_q <= cfg_wdata[WW-1:0];
      end
      assign station[LO +: WW] = word_q;
   end

   // Hash table words.
   for (genvar t = 0; t < TBL_WORDS; t++) begin : g_tbl
      localparam logic [CFG_AW-1:0] TADDR = CFG_AW'(TBL_BASE + t);
      logic [CFG_DW-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '0;
         else if (cfg_we && cfg_addr == TADDR)
            word_q <= cfg_wdata;
      end
      assign table_bits[t*CFG_DW +: CFG_DW] = word_q;
   end

   // Mode: bit 1 promiscuous, bit 0 all-group.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode <= '0;
      else if (cfg_we && cfg_addr == MODE_ADDR)
         mode <= daf_mode_t'(cfg_wdata[1:0]);
   end

endmodule

// File: rtl/daf_addr_track.sv
`timescale 1ns/1ps
module daf_addr_track
   import daf_pkg::*;
#(
   parameter int                   ADDR_BYTES = 6,
   parameter int                   HASH_BITS  = 6,
   parameter logic [DAF_CRC_W-1:0] CRC_POLY   = 32'h04C11DB7,
   localparam int                  ADDR_W     = 8 * ADDR_BYTES
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_valid,
   input  logic                 rx_sof,
   input  logic [7:0]           rx_byte,
   output logic                 addr_done,
   output logic [ADDR_W-1:0]    addr_full,
   output logic [HASH_BITS-1:0] hash_idx
);
   localparam int CNT_W = $clog2(ADDR_BYTES + 1);
   localparam logic [CNT_W-1:0] IDLE = CNT_W'(ADDR_BYTES);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);

   if (ADDR_BYTES < 2) begin : g_chk_len
      $error("address must be at least two bytes");
   end
   if (HASH_BITS < 1 || HASH_BITS > DAF_CRC_W) begin : g_chk_hash
      $error("hash index width out of range");
   end

   logic [CNT_W-1:0]     cnt_q;
   logic [CNT_W-1:0]     pos;
   logic                 take;
   logic [ADDR_W-9:0]    addr_q;
   logic [ADDR_W-1:0]    addr_nx;
   logic [DAF_CRC_W-1:0] crc_q;
   logic [DAF_CRC_W-1:0] crc_seed;
   logic [DAF_CRC_W-1:0] crc_nx;

   always_comb begin
      pos       = rx_sof ? '0 : cnt_q;
      take      = rx_valid && (rx_sof || cnt_q != IDLE);
      crc_seed  = rx_sof ? '1 : crc_q;
      crc_nx    = daf_crc_byte(crc_seed, rx_byte, CRC_POLY);
      addr_nx   = {addr_q, rx_byte};
      addr_done = take && (pos == LAST);
      addr_full = addr_nx;
      hash_idx  = crc_nx[DAF_CRC_W-1 -: HASH_BITS];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= IDLE;
         crc_q  <= '1;
         addr_q <= '0;
      end else if (take) begin
         cnt_q  <= pos + 1'b1;
         crc_q  <= crc_nx;
         addr_q <= addr_nx[ADDR_W-9:0];
      end
   end

endmodule

// File: rtl/daf_decide.sv
`timescale 1ns/1ps
module daf_decide
   import daf_pkg::*;
#(
   parameter int  ADDR_W    = 48,
   parameter int  HASH_BITS = 6,
   localparam int TBL_W     = 1 << HASH_BITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 addr_done,
   input  logic [ADDR_W-1:0]    addr_full,
   input  logic [HASH_BITS-1:0] hash_idx,
   input  logic [ADDR_W-1:0]    station,
   input  logic [TBL_W-1:0]     table_bits,
   input  daf_mode_t            mode,
   output logic                 dec_valid,
   output logic                 dec_accept,
   output daf_reason_e          dec_reason
);
   logic        is_group;
   logic        is_bcast;
   logic        tbl_hit;
   logic        sta_hit;
   logic        acc;
   daf_reason_e rsn;

   always_comb begin
      is_group = addr_full[ADDR_W-8];
      is_bcast = &addr_full;
      tbl_hit  = table_bits[hash_idx];
      sta_hit  = (addr_full == station);
      acc      = 1'b1;
      if (mode.promisc)
         rsn = RSN_PROMISC;
      else if (is_bcast)
         rsn = RSN_BCAST;
      else if (is_group && mode.all_group)
         rsn = RSN_ALLGRP;
      else if (is_group && tbl_hit)
         rsn = RSN_HASH;
      else if (!is_group && sta_hit)
         rsn = RSN_STATION;
      else begin
         rsn = RSN_REJECT;
         acc = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_accept <= 1'b0;
         dec_reason <= RSN_REJECT;
      end else begin
         dec_valid  <= addr_done;
         dec_accept <= addr_done && acc;
         dec_reason <= addr_done ? rsn : RSN_REJECT;
      end
   end

endmodule

// File: rtl/dest_addr_filter.sv
`timescale 1ns/1ps
module dest_addr_filter
   import daf_pkg::*;
#(
   parameter int                   CFG_DW     = 32,
   parameter int                   CFG_AW     = 3,
   parameter int                   ADDR_BYTES = 6,
   parameter int                   HASH_BITS  = 6,
   parameter logic [DAF_CRC_W-1:0] CRC_POLY   = 32'h04C11DB7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [CFG_DW-1:0] cfg_wdata,
   input  logic              rx_valid,
   input  logic              rx_sof,
   input  logic [7:0]        rx_byte,
   output logic              dec_valid,
   output logic              dec_accept,
   output logic [2:0]        dec_reason
);
   localparam int ADDR_W = 8 * ADDR_BYTES;
   localparam int TBL_W  = 1 << HASH_BITS;

   logic [ADDR_W-1:0]    station;
   logic [TBL_W-1:0]     table_bits;
   daf_mode_t            cfg_mode;
   logic                 mode_promisc;
   logic                 addr_done;
   logic [ADDR_W-1:0]    addr_full;
   logic [HASH_BITS-1:0] hash_idx;
   daf_reason_e          reason_e;

   assign mode_promisc = cfg_mode.promisc;
   assign dec_reason   = reason_e;

   daf_cfg_regs #(
      .CFG_DW (CFG_DW),
      .CFG_AW (CFG_AW),
      .STA_W  (ADDR_W),
      .TBL_W  (TBL_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_addr   (cfg_addr),
      .cfg_wdata  (cfg_wdata),
      .station    (station),
      .table_bits (table_bits),
      .mode       (cfg_mode)
   );

   daf_addr_track #(
      .ADDR_BYTES (ADDR_BYTES),
      .HASH_BITS  (HASH_BITS),
      .CRC_POLY   (CRC_POLY)
   ) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_valid  (rx_valid),
      .rx_sof    (rx_sof),
      .rx_byte   (rx_byte),
      .addr_done (addr_done),
      .addr_full (addr_full),
      .hash_idx  (hash_idx)
   );

   daf_decide #(
      .ADDR_W    (ADDR_W),
      .HASH_BITS (HASH_BITS)
   ) u_decide (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_done  (addr_done),
      .addr_full  (addr_full),
      .hash_idx   (hash_idx),
      .station    (station),
      .table_bits (table_bits),
      .mode       (cfg_mode),
      .dec_valid  (dec_valid),
      .dec_accept (dec_accept),
      .dec_reason (reason_e)
   );

endmodule

// File: rtl/daf_checker.sv
`timescale 1ns/1ps
module daf_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       rx_valid,
   input logic [7:0] rx_byte,
   input logic       dec_valid,
   input logic       dec_accept,
   input logic [2:0] dec_reason,
   input logic       mode_promisc
);
   // R2: the strobe never lasts two cycles
   a_r2_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |=> !dec_valid);

   // R2: a decision always follows a sampled byte
   a_r2_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> $past(rx_valid));

   // R2: outputs quiet between decisions
   a_r2_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> (!dec_accept && dec_reason == 3'd0));

   // R4: promiscuous mode accepts everything
   a_r4_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && $past(mode_promisc)) |-> (dec_accept && dec_reason == 3'd1));

   // R5: broadcast reason only when the last byte was all ones
   a_r5_bcast_last_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_reason == 3'd2) |-> ($past(rx_byte) == 8'hFF));

   // R7: rejects always carry reason 0
   a_r7_reject_code: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !dec_accept) |-> (dec_reason == 3'd0));

   // R8: station match never reported while promiscuous
   a_r8_station_not_promisc: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_reason == 3'd5) |-> !$past(mode_promisc));

endmodule

bind dest_addr_filter daf_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rx_valid     (rx_valid),
   .rx_byte      (rx_byte),
   .dec_valid    (dec_valid),
   .dec_accept   (dec_accept),
   .dec_reason   (dec_reason),
   .mode_promisc (mode_promisc)
);

// File: tb/dest_addr_filter_tb.sv
`timescale 1ns/1ps
module dest_addr_filter_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        rx_valid = 1'b0;
   logic        rx_sof = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        dec_valid;
   logic        dec_accept;
   logic [2:0]  dec_reason;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dest_addr_filter u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_sof(rx_sof),
      .rx_byte(rx_byte), .dec_valid(dec_valid), .dec_accept(dec_accept),
      .dec_reason(dec_reason)
   );

   // ---------------- reference model ----------------
   logic [47:0] m_sta;
   logic [63:0] m_tbl;
   logic [1:0]  m_mode;
   int          m_cnt;
   logic [47:0] m_addr;
   logic        exp_valid, exp_acc;
   logic [2:0]  exp_rsn;

   function automatic logic [31:0] ref_crc(input logic [47:0] a);
      logic [31:0] c;
      c = 32'hFFFF_FFFF;
      for (int i = 0; i < 48; i++) begin
         logic bv;
         bv = a[40 - 8*(i/8) + (i%8)];
         if (c[31] ^ bv) c = (c << 1) ^ 32'h04C1_1DB7;
         else            c = c << 1;
      end
      return c;
   endfunction

   function automatic int ref_bucket(input logic [47:0] a);
      logic [31:0] c;
      c = ref_crc(a);
      return int'(c[31:26]);
   endfunction

   function automatic string tag_of(input logic [2:0] r);
      case (r)
         3'd1: return "R4";
         3'd2: return "R5";
         3'd3: return "R6";
         3'd5: return "R8";
         default: return "R7";
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sta = '0; m_tbl = '0; m_mode = '0; m_cnt = 6; m_addr = '0;
         exp_valid = 0; exp_acc = 0; exp_rsn = 0;
      end else begin
         exp_valid = 0; exp_acc = 0; exp_rsn = 0;
         if (rx_valid && (rx_sof || m_cnt != 6)) begin
            if (rx_sof) m_cnt = 0;
            m_addr = {m_addr[39:0], rx_byte};
            m_cnt++;
            if (m_cnt == 6) begin
               exp_valid = 1;
               exp_acc = 1;
               if (m_mode[1])                               exp_rsn = 3'd1;
               else if (m_addr == 48'hFFFF_FFFF_FFFF)       exp_rsn = 3'd2;
               else if (m_addr[40] && m_mode[0])            exp_rsn = 3'd3;
               else if (m_addr[40] && m_tbl[ref_bucket(m_addr)]) exp_rsn = 3'd4;
               else if (!m_addr[40] && m_addr == m_sta)     exp_rsn = 3'd5;
               else begin exp_rsn = 3'd0; exp_acc = 0; end
            end
         end
         if (cfg_we) begin
            case (cfg_addr)
               3'd0: m_sta[31:0]  = cfg_wdata;
               3'd1: m_sta[47:32] = cfg_wdata[15:0];
               3'd2: m_tbl[31:0]  = cfg_wdata;
               3'd3: m_tbl[63:32] = cfg_wdata;
               3'd4: m_mode       = cfg_wdata[1:0];
               default: ;
            endcase
         end
      end
   end

   // ---------------- per-cycle comparison and capture ----------------
   int         dec_seen = 0;
   logic       last_acc = 0;
   logic [2:0] last_rsn = 0;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (dec_valid !== exp_valid) begin
            errors++;
            $display("FAIL R2 cycle strobe actual=%0b expected=%0b", dec_valid, exp_valid);
         end else if (exp_valid && (dec_accept !== exp_acc || dec_reason !== exp_rsn)) begin
            errors++;
            $display("FAIL %s cycle decision actual=%0b/%0d expected=%0b/%0d",
                     tag_of(exp_rsn), dec_accept, dec_reason, exp_acc, exp_rsn);
         end
         if (dec_valid) begin
            dec_seen++;
            last_acc = dec_accept;
            last_rsn = dec_reason;
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic push(input logic [7:0] b, input logic s);
      @(negedge clk);
      rx_valid = 1; rx_sof = s; rx_byte = b;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_valid = 0; rx_sof = 0; rx_byte = '0;
      end
   endtask

   task automatic send(input logic [47:0] a);
      for (int i = 0; i < 6; i++) push(a[47 - 8*i -: 8], i == 0);
      idle(2);
   endtask

   task automatic frame(input logic [47:0] a, input logic acc,
                        input logic [2:0] rsn, input string tag);
      int base;
      base = dec_seen;
      send(a);
      checks++;
      if (dec_seen != base + 1 || last_acc !== acc || last_rsn !== rsn) begin
         errors++;
         $display("FAIL %s addr=%012h actual=n%0d/%0b/%0d expected=n1/%0b/%0d",
                  tag, a, dec_seen - base, last_acc, last_rsn, acc, rsn);
      end
   endtask

   task automatic expect_count(input int base, input int n, input string tag);
      checks++;
      if (dec_seen - base != n) begin
         errors++;
         $display("FAIL %s decision count actual=%0d expected=%0d", tag, dec_seen - base, n);
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // ---------------- test sequence ----------------
   localparam logic [47:0] STA  = 48'h0211_2233_4455;
   localparam logic [47:0] GRP  = 48'h0100_5E00_0001;
   localparam logic [47:0] BCST = 48'hFFFF_FFFF_FFFF;

   initial begin
      int base;
      int b0;
      logic [47:0] grp2;
      repeat (3) @(negedge clk);
      rst_n = 1;
      idle(3);

      // R1: reset state
      expect_count(0, 0, "R1");
      frame(48'h0, 1, 3'd5, "R1");
      frame(GRP, 0, 3'd0, "R1");

      // R3/R8: station programming and matching
      wr(3'd0, STA[31:0]);
      wr(3'd1, {16'hABCD, STA[47:32]});
      frame(STA, 1, 3'd5, "R3");
      frame(STA ^ 48'h1, 0, 3'd0, "R8");
      frame(48'h0, 0, 3'd0, "R8");

      // R5: broadcast with empty table
      frame(BCST, 1, 3'd2, "R5");

      // R7: table hit and miss
      b0 = ref_bucket(GRP);
      grp2 = GRP;
      for (int k = 2; k < 256; k++) begin
         grp2 = {GRP[47:8], 8'(k)};
         if (ref_bucket(grp2) != b0) break;
      end
      wr(3'd2, (b0 < 32) ? (32'h1 << b0) : 32'h0);
      wr(3'd3, (b0 >= 32) ? (32'h1 << (b0 - 32)) : 32'h0);
      frame(GRP, 1, 3'd4, "R7");
      frame(grp2, 0, 3'd0, "R7");
      wr(3'd2, (b0 < 32) ? ~(32'h1 << b0) : 32'hFFFF_FFFF);
      wr(3'd3, (b0 >= 32) ? ~(32'h1 << (b0 - 32)) : 32'hFFFF_FFFF);
      frame(GRP, 0, 3'd0, "R7");
      frame(grp2, 1, 3'd4, "R7");
      wr(3'd2, 32'h0);
      wr(3'd3, 32'h0);

      // R6: all-group mode
      wr(3'd4, 32'h1);
      frame(GRP, 1, 3'd3, "R6");
      frame(STA ^ 48'h10, 0, 3'd0, "R6");
      frame(STA, 1, 3'd5, "R6");
      frame(BCST, 1, 3'd2, "R5");
      wr(3'd4, 32'h0);

      // R3: unmapped addresses change nothing
      wr(3'd5, 32'hFFFF_FFFF);
      wr(3'd6, 32'hFFFF_FFFF);
      wr(3'd7, 32'hFFFF_FFFF);
      frame(STA, 1, 3'd5, "R3");
      frame(STA ^ 48'h2, 0, 3'd0, "R3");
      frame(GRP, 0, 3'd0, "R3");

      // R4: promiscuous, both encodings
      wr(3'd4, 32'h2);
      frame(STA ^ 48'h4, 1, 3'd1, "R4");
      frame(BCST, 1, 3'd1, "R4");
      wr(3'd4, 32'h3);
      frame(GRP, 1, 3'd1, "R4");
      wr(3'd4, 32'h0);

      // R2: bytes without a start marker are ignored
      base = dec_seen;
      for (int i = 0; i < 6; i++) push(STA[47 - 8*i -: 8], 1'b0);
      idle(2);
      expect_count(base, 0, "R2");
      // R2: trailing bytes after the sixth produce nothing more
      base = dec_seen;
      for (int i = 0; i < 6; i++) push(STA[47 - 8*i -: 8], i == 0);
      for (int i = 0; i < 4; i++) push(8'hFF, 1'b0);
      idle(2);
      expect_count(base, 1, "R2");
      // R2: a start marker mid-address restarts the count
      push(8'h00, 1'b1); push(8'h11, 1'b0); push(8'h22, 1'b0);
      frame(STA, 1, 3'd5, "R2");

      // R9: mode write on the sixth-byte edge applies to the next frame
      base = dec_seen;
      for (int i = 0; i < 5; i++) push(8'(8'h30 + i), i == 0);
      @(negedge clk);
      rx_valid = 1; rx_sof = 0; rx_byte = 8'h35;
      cfg_we = 1; cfg_addr = 3'd4; cfg_wdata = 32'h2;
      @(negedge clk);
      cfg_we = 0; rx_valid = 0;
      idle(1);
      checks++;
      if (dec_seen != base + 1 || last_acc !== 1'b0 || last_rsn !== 3'd0) begin
         errors++;
         $display("FAIL R9 same-edge actual=%0b/%0d expected=0/0", last_acc, last_rsn);
      end
      frame(48'h3031_3233_3435, 1, 3'd1, "R9");

      idle(3);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule